// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. A producer presents a byte with a valid/ready handshake. The block accepts it only while no frame is in flight. It then drives a start bit, the data bits least significant first, an optional parity bit and the stop bits. After that it returns the line to its idle high level.

The frame shape comes from an 8-bit line control input. That input selects a character length of 5 to 8 bits, one or two stop bits (one and a half for 5-bit characters), whether a parity bit is sent, and which parity rule applies: odd, even, forced one or forced zero. Timing is paced by an external enable that pulses sixteen times per bit period. The format is captured when a character is accepted, so the rest of the system may reprogram the control byte while a frame is still going out. One control bit does not wait for a frame boundary: it pulls the line low at once for as long as it is set.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight and the break bit is clear, `tx_line` is 1, `busy` is 0 and `tx_ready` is 1.
- R2: A character is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. From the next cycle until the frame ends, `busy` is 1 and `tx_ready` is 0.
- R3: A frame starts with a 0 start bit. Every start, data and parity bit lasts exactly 16 tick pulses. Cycles without a tick pulse do not advance the frame or change the line.
- R4: Control bits [1:0] set the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits go out least significant bit first.
- R5: When control bit 3 is 1, a parity bit follows the data. Control bits [5:4] pick its value: 00 makes the count of ones in data plus parity odd, 01 makes it even, 10 sends a constant 1 and 11 sends a constant 0.
- R6: The stop level is 1. With control bit 2 at 0 it lasts 16 ticks. With bit 2 at 1 it lasts 32 ticks, or 24 ticks when the length field is 00. After the stop ticks, `busy` falls and the line stays 1.
- R7: While control bit 6 is 1, `tx_line` is 0 in the same cycle, whether the block is idle or mid-frame. Frame timing is not affected.
- R8: The format fields (bits 5:0) are captured when a character is accepted. Changes to them during the frame have no effect on that frame.
- R9: Data bits above the selected length are neither sent nor counted in the parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable, sixteen pulses per bit |
| line_ctrl | input | 8 | Frame format and break control |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Block can accept a character |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | Frame in flight |

## Verification
Almost every internal fault shows up on `tx_line` inside the frame it affects. A wrong bit index or shift shows as a swapped data level within 16 ticks of the bad bit. A wrong parity selection corrupts exactly one bit period. A miscounted stop span moves the fall of `busy` by 8 or 16 ticks. A tick counter that drifts without a tick pulse changes the line during a stalled stretch of plain clock cycles. Because the bench compares the line level on every tick of each frame, any of these is caught by the end of the frame that triggers it.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int CHAR_MAX = 8;
  localparam int BRK_BIT  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_t;

  typedef enum logic [1:0] {
    PM_ODD  = 2'b00,
    PM_EVEN = 2'b01,
    PM_ONE  = 2'b10,
    PM_ZERO = 2'b11
  } par_mode_t;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    par_mode_t  par_mode;
    logic       stop_long;
    logic       short_char;
  } frame_cfg_t;

  // Turn the raw format bits into a decoded frame description.
  function automatic frame_cfg_t decode_fmt(input logic [5:0] f);
    frame_cfg_t c;
    c.nbits      = 4'd5 + {2'b00, f[1:0]};
    c.stop_long  = f[2];
    c.par_en     = f[3];
    c.par_mode   = par_mode_t'(f[5:4]);
    c.short_char = (f[1:0] == 2'b00);
    return c;
  endfunction

  // Parity bit over the low n data bits for the chosen mode.
  function automatic logic calc_parity(input logic [CHAR_MAX-1:0] d,
                                       input logic [3:0] n,
                                       input par_mode_t mode);
    logic x;
    x = 1'b0;
    for (int i = 0; i < CHAR_MAX; i++) begin
      if (i < int'(n)) x = x ^ d[i];
    end
    case (mode)
      PM_ODD:  return ~x;
      PM_EVEN: return x;
      PM_ONE:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Ticks spent at the stop level.
  function automatic int stop_span(input frame_cfg_t c, input int tpb);
    if (!c.stop_long) return tpb;
    if (c.short_char) return tpb + tpb / 2;
    return 2 * tpb;
  endfunction

endpackage

// File: rtl/utx_fmt_hold.sv
module utx_fmt_hold
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [5:0] fmt_in,
  output frame_cfg_t cfg
);

  logic [5:0] fmt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    fmt_q <= '0;
    else if (load) fmt_q <= fmt_in;
  end

  assign cfg = decode_fmt(fmt_q);

  // R8: captured format changes only on a load
  p_fmt_only_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg));

endmodule

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] span,
  output logic             phase_done
);

  logic [CNT_W-1:0] cnt;
  logic             at_last;

  assign at_last    = (cnt == span - CNT_W'(1));
  assign phase_done = run && tick && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)     cnt <= '0;
    else if (phase_done)   cnt <= '0;
    else if (run && tick)  cnt <= cnt + CNT_W'(1);
  end

  // R3: count never reaches the span of the running phase
  p_cnt_in_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < span));

  // R3: no tick pulse, no progress
  p_hold_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));

endmodule

// File: rtl/utx_sequencer.sv
module utx_sequencer
  import uart_tx_pkg::*;
#(
  parameter int TPB   = 16,
  parameter int CNT_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [CHAR_MAX-1:0] data_in,
  input  frame_cfg_t          cfg,
  input  logic                phase_done,
  output logic                run,
  output logic [CNT_W-1:0]    span,
  output logic                line_raw,
  output logic                frame_end
);

  localparam int IDX_W = $clog2(CHAR_MAX);

  tx_state_t           state;
  logic [CHAR_MAX-1:0] shreg;
  logic [IDX_W-1:0]    bit_idx;
  logic                par_q;
  logic                last_data;

  assign last_data = ({1'b0, bit_idx} == (cfg.nbits - 4'd1));
  assign run       = (state != ST_IDLE);
  assign frame_end = phase_done && (state == ST_STOP);
  assign span      = (state == ST_STOP) ? CNT_W'(stop_span(cfg, TPB)) : CNT_W'(TPB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      par_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_START;
          shreg   <= data_in;
          bit_idx <= '0;
        end
        ST_START: if (phase_done) begin
          state <= ST_DATA;
          par_q <= calc_parity(shreg, cfg.nbits, cfg.par_mode);
        end
        ST_DATA: if (phase_done) begin
          shreg   <= shreg >> 1;
          bit_idx <= bit_idx + IDX_W'(1);
          if (last_data) state <= cfg.par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR:  if (phase_done) state <= ST_STOP;
        ST_STOP: if (phase_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_START: line_raw = 1'b0;
      ST_DATA:  line_raw = shreg[0];
      ST_PAR:   line_raw = par_q;
      default:  line_raw = 1'b1;
    endcase
  end

  // R2: an accepted character opens a frame with the start bit
  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state == ST_START) && !line_raw);

  // R4: bit index stays inside the selected length
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> ({1'b0, bit_idx} < cfg.nbits));

  // R5: parity state only entered when parity is enabled
  p_par_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAR) |-> cfg.par_en);

  // R6: stop level is high
  p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |-> line_raw);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [7:0] line_ctrl,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       tx_line,
  output logic       busy
);

  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);

  frame_cfg_t       cfg;
  logic             accept;
  logic             run;
  logic             phase_done;
  logic             frame_end;
  logic             line_raw;
  logic [CNT_W-1:0] span;
  logic             brk;

  assign accept   = tx_valid && tx_ready;
  assign tx_ready = !run;
  assign busy     = run;
  assign brk      = line_ctrl[BRK_BIT];
  assign tx_line  = brk ? 1'b0 : line_raw;

  utx_fmt_hold u_fmt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .fmt_in (line_ctrl[5:0]),
    .cfg    (cfg)
  );

  utx_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (accept),
    .run        (run),
    .tick       (tick16),
    .span       (span),
    .phase_done (phase_done)
  );

  utx_sequencer #(.TPB(TICKS_PER_BIT), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .data_in    (tx_data),
    .cfg        (cfg),
    .phase_done (phase_done),
    .run        (run),
    .span       (span),
    .line_raw   (line_raw),
    .frame_end  (frame_end)
  );

  // R1: idle without break leaves the line high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> tx_line);

  // R7: break holds the output low
  p_break_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !tx_line);

  // R8: format held between acceptance and the end of the frame
  p_cfg_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_end) |=> $stable(cfg));

  // R6: frame end returns the block to idle
  p_end_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !busy && tx_ready);

endmodule

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [7:0] line_ctrl = 8'h00;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, tx_line, busy;

  int checks = 0;
  int failures = 0;
  bit tick_en = 1'b1;

  always #4 clk = ~clk;

  uart_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_ctrl(line_ctrl),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_line(tx_line), .busy(busy)
  );

  // tick pulse every third cycle, updated just after the rising edge
  initial begin
    int phase = 0;
    forever begin
      @(posedge clk);
      #1;
      tick16 = tick_en && (phase == 2);
      phase = (phase == 2) ? 0 : phase + 1;
    end
  end

  initial begin
    #1_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int char_len(input logic [7:0] l);
    return 5 + int'(l[1:0]);
  endfunction

  function automatic int stop_ticks(input logic [7:0] l);
    if (l[2] == 1'b0) return 16;
    return (l[1:0] == 2'b00) ? 24 : 32;
  endfunction

  function automatic int frame_ticks(input logic [7:0] l);
    return 16 * (1 + char_len(l) + int'(l[3])) + stop_ticks(l);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [7:0] l);
    int ones = 0;
    for (int i = 0; i < char_len(l); i++) ones += int'(d[i]);
    case (l[5:4])
      2'b00: return (ones % 2 == 0);
      2'b01: return (ones % 2 == 1);
      2'b10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_level(input logic [7:0] d, input logic [7:0] l, input int k);
    int b = k / 16;
    int n = char_len(l);
    if (b == 0) return 1'b0;
    if (b <= n) return d[b-1];
    if (l[3] && b == n + 1) return exp_par(d, l);
    return 1'b1;
  endfunction

  // Sends one frame, compares the line on every tick, checks handshake and end.
  task automatic send_frame(input logic [7:0] d, input logic [7:0] l, input string req,
                            input logic [7:0] l_mid, input int brk_from, input int brk_to,
                            input int stall_at);
    int total = frame_ticks(l);
    int bad = 0;
    int first_k = -1;
    int first_act = 0;
    int first_exp = 0;
    int k = 0;
    @(negedge clk);
    check(tx_ready === 1'b1, {req, " ready before send"}, int'(tx_ready), 1);
    tx_data  = d;
    line_ctrl = l;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data  = ~d;
    check(busy === 1'b1 && tx_ready === 1'b0, {req, " R2 busy after accept"},
          int'(busy), 1);
    while (k < total) begin
      if (tick16) begin
        logic exp_v;
        line_ctrl = ((k >= 20) ? l_mid : l) & 8'hBF;
        if (k >= brk_from && k < brk_to) line_ctrl[6] = 1'b1;
        #1;
        exp_v = (k >= brk_from && k < brk_to) ? 1'b0 : exp_level(d, l, k);
        if (tx_line !== exp_v) begin
          bad++;
          if (first_k < 0) begin
            first_k = k; first_act = int'(tx_line); first_exp = int'(exp_v);
          end
        end
        if (busy !== 1'b1) bad++;
        if (k == stall_at) begin
          logic held;
          tick_en = 1'b0;
          @(negedge clk);
          held = tx_line;
          for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            check(tx_line === held && busy === 1'b1, {req, " R3 stalled line"},
                  int'(tx_line), int'(held));
          end
          tick_en = 1'b1;
        end
        k++;
      end
      if (k < total) @(negedge clk);
    end
    check(bad == 0, {req, " line per tick"}, first_act, first_exp);
    if (bad != 0) $display("  first mismatch at tick %0d", first_k);
    @(negedge clk);
    line_ctrl = line_ctrl & 8'hBF;
    #1;
    check(busy === 1'b0 && tx_ready === 1'b1 && tx_line === 1'b1,
          {req, " R6 idle after stop ticks"}, int'(busy), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(tx_line === 1'b1, "R1 reset line", int'(tx_line), 1);
    check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
    check(tx_ready === 1'b1, "R1 reset ready", int'(tx_ready), 1);
  endtask

  task automatic t_idle_break;
    @(negedge clk);
    line_ctrl = 8'h43;
    #1;
    check(tx_line === 1'b0 && busy === 1'b0, "R7 idle break low", int'(tx_line), 0);
    @(negedge clk);
    line_ctrl = 8'h03;
    #1;
    check(tx_line === 1'b1, "R7 break released", int'(tx_line), 1);
  endtask

  task automatic t_no_accept_while_busy;
    // a second offer during a frame must wait: line shows the first char only
    fork
      send_frame(8'h3C, 8'h03, "R2 held offer", 8'h03, -1, -1, -1);
      begin
        repeat (4) @(negedge clk);
        tx_data = 8'hFF;
        tx_valid = 1'b1;
        repeat (20) @(negedge clk);
        tx_valid = 1'b0;
      end
    join
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    send_frame(8'hA5, 8'h03, "R4 R3 8N1", 8'h03, -1, -1, -1);
    send_frame(8'hE3, 8'h00, "R4 R9 5N1", 8'h00, -1, -1, -1);
    send_frame(8'h5B, 8'h1E, "R5 R6 7E2", 8'h1E, -1, -1, -1);
    send_frame(8'h16, 8'h0C, "R6 R5 5O1.5", 8'h0C, -1, -1, -1);
    send_frame(8'h07, 8'h0B, "R5 8O1", 8'h0B, -1, -1, -1);
    send_frame(8'h00, 8'h2B, "R5 stick one", 8'h2B, -1, -1, -1);
    send_frame(8'hFF, 8'h3B, "R5 stick zero", 8'h3B, -1, -1, -1);
    send_frame(8'hC1, 8'h19, "R9 6E1 upper bits", 8'h19, -1, -1, -1);
    send_frame(8'h6D, 8'h05, "R4 6N2", 8'h05, -1, -1, -1);
    send_frame(8'h96, 8'h03, "R8 format change mid", 8'h3C, -1, -1, -1);
    send_frame(8'h81, 8'h0F, "R7 break mid frame", 8'h0F, 30, 55, -1);
    send_frame(8'h4E, 8'h1B, "R3 tick stall", 8'h1B, -1, -1, 37);
    t_idle_break();
    tx_valid = 1'b0;
    @(negedge clk);
    t_no_accept_while_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule